// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block issues clause-22 management transactions on an MDC/MDIO serial pair. Software drives everything through a single 32-bit command/status word. One write holds the target PHY address, the register address, the direction, the write data and the start request. Software then polls the same word until the busy flag drops. After a read completes, the low half of the word holds the value returned by the PHY.

MDC is the system clock divided by a parameter and stays low between transactions. The master changes MDIO just after a falling MDC edge and samples it on a rising edge. During the turnaround and data phases of a read, the master releases the line. A command whose PHY address is outside the populated range never reaches the pins and completes at once. For a read, that completion loads all ones into the data field.

Top module: `mdio_regif_master`

## Requirements
- R1: After reset the word reads 0x00000000, MDC is low, the MDIO output enable is low and the MDIO output is 1.
- R2: Field layout: data [15:0], register address [20:16], PHY address [25:21], read select bit 27 (1 = read, 0 = write), enable bit 30, busy bit 31. Writing busy and enable both set, with a PHY address below NUM_PHYS, makes busy read 1 from the next cycle.
- R3: The frame is 32 ones, start bits 01, opcode 10 for a read or 01 for a write, PHY address, register address, turnaround, then 16 data bits. Every field goes out most significant bit first. A write uses turnaround 10.
- R4: MDC runs with a period of 2*HALF_DIV clocks while busy and is low whenever busy is 0. A frame holds exactly 64 rising MDC edges.
- R5: MDIO and its output enable change only after a falling MDC edge. They are stable throughout each high phase of MDC.
- R6: A write keeps the output enable high for all 64 bits. A read drops it for the last 18 bits (turnaround and data). The enable is low while idle.
- R7: When a read completes, busy is 0 and bits [15:0] hold the 16 bits sampled on the last 16 rising MDC edges, first bit in the most significant position.
- R8: A read command to a PHY address at or above NUM_PHYS produces no MDC activity. From the next cycle it shows busy 0 and data 0xFFFF.
- R9: A write command to a PHY address at or above NUM_PHYS produces no MDC activity, and busy reads 0 from the next cycle.
- R10: A write to the word while busy is 1 has no effect. The readback stays unchanged and no further frame follows.
- R11: A command with busy set but enable clear starts nothing, and busy reads 0.
- R12: Bits 29, 28 and 26 always read 0. When a write frame completes, the word reads back the command with busy cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the command/status word |
| reg_wdata_i | input | 32 | Value written to the word |
| reg_rdata_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The bench builds the block with HALF_DIV = 2 and the default NUM_PHYS = 5. A full 64-bit frame then takes 256 clocks, so several complete read and write frames fit easily in the run. These include a collision in which a command arrives mid-frame, and MDC period measurements at a small, exactly countable divide ratio. With five populated addresses, address 4 is the last valid boundary. Address 5 and address 31 exercise the rejected reads and writes.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int REGA_LSB  = 16;
  localparam int PHYA_LSB  = 21;
  localparam int RD_BIT    = 27;
  localparam int EN_BIT    = 30;
  localparam int BUSY_BIT  = 31;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef enum logic {
    SH_IDLE,
    SH_FRAME
  } sh_state_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] rega;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // event pulses mark the cycle whose edge toggles mdc
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IW      = $clog2(FRAME_LEN);
  localparam int LAST    = FRAME_LEN - 1;
  localparam int TA_IDX  = FRAME_LEN - DATA_W - 2;
  localparam int DAT_IDX = TA_IDX + 2;

  sh_state_e             state_q;
  logic [IW-1:0]         idx_q;
  logic [FRAME_LEN-1:0]  shreg_q;
  logic [FRAME_LEN-1:0]  frame;
  logic                  rd_q;
  logic [DATA_W-1:0]     rdsh_q;
  logic                  at_last;

  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             (cmd_i.rd ? OP_READ : OP_WRITE),
             cmd_i.phy, cmd_i.rega,
             (cmd_i.rd ? 2'b11 : 2'b10),
             (cmd_i.rd ? {DATA_W{1'b1}} : cmd_i.data)};
  end

  assign at_last = (idx_q == IW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      rd_q    <= 1'b0;
      rdsh_q  <= '0;
    end else if (state_q == SH_IDLE) begin
      if (start_i) begin
        state_q <= SH_FRAME;
        idx_q   <= '0;
        shreg_q <= frame;
        rd_q    <= cmd_i.rd;
      end
    end else begin
      if (rise_i && rd_q && (idx_q >= IW'(DAT_IDX)))
        rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (at_last) begin
          state_q <= SH_IDLE;
        end else begin
          idx_q   <= idx_q + IW'(1);
          shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign active_o  = (state_q == SH_FRAME);
  assign done_o    = active_o && fall_i && at_last;
  assign mdio_oe_o = active_o && (!rd_q || (idx_q < IW'(TA_IDX)));
  assign mdio_o    = mdio_oe_o ? shreg_q[FRAME_LEN-1] : 1'b1;
  assign rd_data_o = rdsh_q;
endmodule

// File: rtl/mdio_regif_master.sv
module mdio_regif_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int NUM_PHYS = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy_q, en_q, rd_q;
  logic [ADDR_W-1:0] phy_q, rega_q;
  logic [DATA_W-1:0] data_q;

  mdio_cmd_t         cmd_w;
  logic              wr_ok, go, addr_ok, launch;
  logic              active, done, rise, fall;
  logic [DATA_W-1:0] rd_data;

  assign cmd_w.rd   = reg_wdata_i[RD_BIT];
  assign cmd_w.phy  = reg_wdata_i[PHYA_LSB +: ADDR_W];
  assign cmd_w.rega = reg_wdata_i[REGA_LSB +: ADDR_W];
  assign cmd_w.data = reg_wdata_i[DATA_W-1:0];

  assign wr_ok   = reg_we_i && !busy_q;
  assign go      = reg_wdata_i[BUSY_BIT] && reg_wdata_i[EN_BIT];
  assign addr_ok = int'(cmd_w.phy) < NUM_PHYS;
  assign launch  = wr_ok && go && addr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      rd_q   <= 1'b0;
      phy_q  <= '0;
      rega_q <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      busy_q <= go && addr_ok;
      en_q   <= reg_wdata_i[EN_BIT];
      rd_q   <= cmd_w.rd;
      phy_q  <= cmd_w.phy;
      rega_q <= cmd_w.rega;
      // rejected read completes at once with all ones
      data_q <= (go && cmd_w.rd && !addr_ok) ? {DATA_W{1'b1}} : cmd_w.data;
    end else if (done) begin
      busy_q <= 1'b0;
      if (rd_q) data_q <= rd_data;
    end
  end

  assign reg_rdata_o = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, rega_q, data_q};

  mdio_mdc_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_mdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (launch),
    .cmd_i    (cmd_w),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .active_o (active),
    .done_o   (done),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/mdio_regif_master_chk.sv
module mdio_regif_master_chk #(
  parameter int NUM_PHYS = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic busy, cmd_go, addr_bad;
  assign busy     = reg_rdata_o[31];
  assign cmd_go   = reg_we_i && !busy && reg_wdata_i[31] && reg_wdata_i[30];
  assign addr_bad = int'(reg_wdata_i[25:21]) >= NUM_PHYS;

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && !addr_bad) |=> busy);

  assert_mdc_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  assert_stable_high_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  assert_oe_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);

  assert_bad_read_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && reg_wdata_i[27] && addr_bad) |=> (!busy && reg_rdata_o[15:0] == 16'hFFFF));

  assert_bad_write_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && !reg_wdata_i[27] && addr_bad) |=> !busy);

  assert_busy_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i) |=> (!busy || $stable(reg_rdata_o)));

  assert_enable_needed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !busy && !reg_wdata_i[30]) |=> !busy);
endmodule

bind mdio_regif_master mdio_regif_master_chk #(
  .NUM_PHYS(NUM_PHYS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mdio_regif_master_tb.sv
`timescale 1ns/1ps
module mdio_regif_master_tb;
  localparam int HALF_DIV = 2;
  localparam int NUM_PHYS = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i;

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done_flag = 1'b0;

  int          rise_cnt = 0;
  int          oe_low_cnt = 0;
  int          rise_cyc0 = 0;
  int          rise_cyc1 = 0;
  logic [63:0] cap = '0;
  logic [15:0] phy_val = 16'h0000;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_regif_master #(
    .HALF_DIV(HALF_DIV),
    .NUM_PHYS(NUM_PHYS)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .mdio_i     (mdio_i)
  );

  // PHY model: records each bit on rising MDC
  initial begin : phy_sample
    forever begin
      @(posedge mdc_o);
      if (rise_cnt == 0) rise_cyc0 = cyc;
      if (rise_cnt == 1) rise_cyc1 = cyc;
      cap = {cap[62:0], (mdio_oe_o ? mdio_o : 1'b0)};
      if (!mdio_oe_o) oe_low_cnt++;
      rise_cnt++;
    end
  end

  // PHY model: drives read data after falling MDC
  initial begin : phy_drive
    mdio_i = 1'b1;
    forever begin
      @(negedge mdc_o);
      if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_val[63-rise_cnt];
      else mdio_i = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rega,
                                      input logic [15:0] data);
    return {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, rega, data};
  endfunction

  function automatic logic [63:0] frame(input bit rd, input logic [4:0] phy, input logic [4:0] rega,
                                        input logic [15:0] data);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rega, 2'b10, data};
  endfunction

  task automatic reg_write(input logic [31:0] w);
    @(negedge clk);
    reg_we_i = 1'b1;
    reg_wdata_i = w;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic clear_mon();
    rise_cnt = 0;
    oe_low_cnt = 0;
    cap = '0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && reg_rdata_o[31]; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(reg_rdata_o == 32'h0, "R1 word", reg_rdata_o, 0);
    chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0 && mdio_o == 1'b1, "R1 pins",
        {mdc_o, mdio_oe_o, mdio_o}, 3'b001);
  endtask

  task automatic t_write();
    logic [31:0] w;
    w = cmd(1'b0, 5'd2, 5'd5, 16'hA55A);
    clear_mon();
    reg_write(w);
    chk(reg_rdata_o[31] == 1'b1, "R2 busy set", reg_rdata_o, w);
    wait_idle();
    chk(cap == frame(1'b0, 5'd2, 5'd5, 16'hA55A), "R3 write frame", cap, frame(1'b0, 5'd2, 5'd5, 16'hA55A));
    chk(rise_cnt == 64, "R4 rise count", rise_cnt, 64);
    chk(rise_cyc1 - rise_cyc0 == 2 * HALF_DIV, "R4 mdc period", rise_cyc1 - rise_cyc0, 2 * HALF_DIV);
    chk(mdc_o == 1'b0, "R4 mdc idle", mdc_o, 0);
    chk(oe_low_cnt == 0, "R6 write oe", oe_low_cnt, 0);
    chk(reg_rdata_o == (w & 32'h7FFF_FFFF), "R12 readback", reg_rdata_o, w & 32'h7FFF_FFFF);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rega, input logic [15:0] val);
    logic [63:0] exp;
    exp = frame(1'b1, phy, rega, 16'h0);
    clear_mon();
    phy_val = val;
    reg_write(cmd(1'b1, phy, rega, 16'h0));
    wait_idle();
    chk(cap[63:18] == exp[63:18], "R3 read header", cap[63:18], exp[63:18]);
    chk(oe_low_cnt == 18, "R6 read release", oe_low_cnt, 18);
    chk(reg_rdata_o[31] == 1'b0 && reg_rdata_o[15:0] == val, "R7 read data", reg_rdata_o, val);
  endtask

  task automatic t_bad_read();
    clear_mon();
    reg_write(cmd(1'b1, 5'd5, 5'd1, 16'h0));
    chk(reg_rdata_o[31] == 1'b0, "R8 busy", reg_rdata_o, 0);
    chk(reg_rdata_o[15:0] == 16'hFFFF, "R8 data", reg_rdata_o[15:0], 16'hFFFF);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 0, "R8 no mdc", rise_cnt, 0);
  endtask

  task automatic t_bad_write();
    clear_mon();
    reg_write(cmd(1'b0, 5'd31, 5'd1, 16'h1111));
    chk(reg_rdata_o[31] == 1'b0, "R9 busy", reg_rdata_o, 0);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 0, "R9 no mdc", rise_cnt, 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] w;
    w = cmd(1'b1, 5'd1, 5'd2, 16'h0);
    clear_mon();
    phy_val = 16'hBEEF;
    reg_write(w);
    repeat (20) @(negedge clk);
    reg_write(cmd(1'b0, 5'd3, 5'd7, 16'h0F0F));
    chk(reg_rdata_o == w, "R10 word kept", reg_rdata_o, w);
    wait_idle();
    chk(reg_rdata_o[15:0] == 16'hBEEF && reg_rdata_o[25:21] == 5'd1, "R10 result", reg_rdata_o, 16'hBEEF);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 64, "R10 single frame", rise_cnt, 64);
  endtask

  task automatic t_enable_off();
    clear_mon();
    reg_write(32'h8000_0000 | (32'd1 << 21));
    chk(reg_rdata_o[31] == 1'b0, "R11 busy", reg_rdata_o, 0);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 0, "R11 no mdc", rise_cnt, 0);
  endtask

  task automatic t_reserved();
    reg_write(32'h7FFF_FFFF);
    chk(reg_rdata_o == 32'h4BFF_FFFF, "R12 reserved", reg_rdata_o, 32'h4BFF_FFFF);
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_write();
    t_read(5'd4, 5'd3, 16'h1234);
    t_read(5'd0, 5'd31, 16'h8001);
    t_bad_read();
    t_bad_write();
    t_busy_write();
    t_enable_off();
    t_reserved();
    report();
  end
endmodule